// File: doc/BRIEF.md
# Wide-Word Memory with Per-Lane Error Correction

This block is a small word-organised memory whose physical word is 128 bits. The word is split into four 32-bit lanes, and each lane is stored as its own 38-bit single-error-correcting code word: 32 data bits plus 6 check bits. The code is a Hamming code. Because each lane carries its own check bits, a requester can replace one lane without reading or rewriting the other three lanes of that word.

There are three read paths, and every one has a latency of one cycle. The full-word read returns all four lanes, each corrected on its own, together with a corrected-error flag for each lane. The narrow read returns one chosen lane through a lane multiplexer. The block-fill port streams a 256-bit block as two consecutive words on two back-to-back cycles. A test-only injection port flips one stored bit of one lane, so that the correction logic can be exercised from the ports.

Top module: `lane_ecc_mem`

## Requirements
- R1: After reset, every word reads as all zeros with no correction flags set, and `rd_valid`, `nrd_valid` and `fill_valid` are low.
- R2: A full write (`wr_full`=1) stores all 128 bits of `wr_data`. A read with `rd_en` high returns that word on `rd_data` with `rd_valid` high in the next cycle. `rd_valid` is low in the cycle after `rd_en` was low.
- R3: A lane write (`wr_full`=0) stores `wr_data[31:0]` into lane `wr_lane`, where lane k occupies bits 32k+31..32k of the word. The other lanes of that word keep their values.
- R4: A lane write leaves the stored code words of the other lanes untouched. An error injected earlier into another lane of the same word is still reported after the lane write.
- R5: A single flipped bit in any of the 38 stored positions of a lane (`inj_bit` 0..37, covering data and check bits) is corrected on read. `inj_bit` values from 38 to 63 change nothing.
- R6: `rd_corr[k]` is high, in the same cycle as the data, exactly for the lanes whose stored code word held an error. Writing a lane clears its error. All flags are low whenever `rd_valid` is low.
- R7: A narrow read (`nrd_en`) of lane `nrd_lane` returns the corrected 32-bit lane on `nrd_data` one cycle later, with `nrd_valid` and `nrd_corr` for that lane.
- R8: A fill request for block b returns word 2b, with `fill_valid` high and `fill_last` low, in the next cycle. It returns word 2b+1, with `fill_valid` and `fill_last` both high, in the cycle after that. `fill_corr` carries the per-lane flags of each beat.
- R9: A fill request that arrives while the second beat of a fill is still pending is ignored. No third beat follows.
- R10: A read issued in the same cycle as a write to the same address returns the content from before the write.
- R11: An injection in a cycle where `wr_en` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_full | input | 1 | 1: write the whole word, 0: write one lane |
| wr_lane | input | 2 | Lane selected for a lane write |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 128 | Write data; a lane write uses bits 31..0 |
| rd_en | input | 1 | Full-word read strobe |
| rd_addr | input | 4 | Full-word read address |
| rd_data | output | 128 | Corrected read word |
| rd_corr | output | 4 | Per-lane corrected flags |
| rd_valid | output | 1 | Read result valid |
| nrd_en | input | 1 | Narrow read strobe |
| nrd_addr | input | 4 | Narrow read address |
| nrd_lane | input | 2 | Lane returned by the narrow read |
| nrd_data | output | 32 | Corrected lane data |
| nrd_corr | output | 1 | Lane was corrected |
| nrd_valid | output | 1 | Narrow result valid |
| fill_req | input | 1 | Block fill request |
| fill_blk | input | 3 | Block index (words 2b and 2b+1) |
| fill_data | output | 128 | Current fill beat |
| fill_corr | output | 4 | Per-lane flags of the beat |
| fill_valid | output | 1 | Beat valid |
| fill_last | output | 1 | Second beat of the block |
| inj_en | input | 1 | Error injection strobe (test only) |
| inj_addr | input | 4 | Word to corrupt |
| inj_lane | input | 2 | Lane to corrupt |
| inj_bit | input | 6 | Code word bit to flip (0..37) |

## Verification
Every result comes from a single register after the array, so a read, narrow read or injection appears one cycle after its strobe. The bench drives inputs just after a falling edge and samples just after the next falling edge, which lands exactly on that registered output. The two fill beats come on the first and second cycles after the request, so the bench samples on two consecutive falling edges, and on a third to confirm the port goes quiet. Writes and injections become visible to a read issued in the cycle after them, and the bench orders its stimulus to match.

// File: rtl/lane_ecc_mem.sv
module lane_ecc_mem #(
  parameter int DEPTH = 16,
  parameter int NL    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_full,
  input  logic [$clog2(NL)-1:0]     wr_lane,
  input  logic [$clog2(DEPTH)-1:0]  wr_addr,
  input  logic [NL*32-1:0]          wr_data,
  input  logic                      rd_en,
  input  logic [$clog2(DEPTH)-1:0]  rd_addr,
  output logic [NL*32-1:0]          rd_data,
  output logic [NL-1:0]             rd_corr,
  output logic                      rd_valid,
  input  logic                      nrd_en,
  input  logic [$clog2(DEPTH)-1:0]  nrd_addr,
  input  logic [$clog2(NL)-1:0]     nrd_lane,
  output logic [31:0]               nrd_data,
  output logic                      nrd_corr,
  output logic                      nrd_valid,
  input  logic                      fill_req,
  input  logic [$clog2(DEPTH)-2:0]  fill_blk,
  output logic [NL*32-1:0]          fill_data,
  output logic [NL-1:0]             fill_corr,
  output logic                      fill_valid,
  output logic                      fill_last,
  input  logic                      inj_en,
  input  logic [$clog2(DEPTH)-1:0]  inj_addr,
  input  logic [$clog2(NL)-1:0]     inj_lane,
  input  logic [5:0]                inj_bit
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(NL);
  localparam int CW = 38;

  function automatic logic [CW-1:0] enc(input logic [31:0] d);
    logic [63:0] c;
    logic        x;
    int          k;
    c = '0;
    k = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p[5:0]] = d[k[4:0]];
        k++;
      end
    for (int b = 0; b < 6; b++) begin
      x = 1'b0;
      for (int p = 1; p <= CW; p++)
        if (p[b]) x = x ^ c[p[5:0]];
      c[(1 << b)] = x;
    end
    return c[CW:1];
  endfunction

  function automatic logic [32:0] dec(input logic [CW-1:0] cw);
    logic [63:0] c;
    logic [5:0]  s;
    logic [31:0] d;
    int          k;
    c = {{(63 - CW){1'b0}}, cw, 1'b0};
    s = '0;
    d = '0;
    for (int p = 1; p <= CW; p++)
      if (c[p[5:0]]) s = s ^ p[5:0];
    if (s != 6'd0) c[s] = ~c[s];
    k = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[k[4:0]] = c[p[5:0]];
        k++;
      end
    return {s != 6'd0, d};
  endfunction

  logic [CW-1:0] mem [DEPTH][NL];
  logic          fill_busy;
  logic [AW-2:0] blk_q;
  logic          fill_go;
  logic [AW-1:0] fill_addr;
  logic [32:0]   rd_dec   [NL];
  logic [32:0]   fill_dec [NL];
  logic [32:0]   nrd_dec;

  assign fill_go   = fill_req && !fill_busy;
  assign fill_addr = fill_busy ? {blk_q, 1'b1} : {fill_blk, 1'b0};
  assign nrd_dec   = dec(mem[nrd_addr][nrd_lane]);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign rd_dec[l]   = dec(mem[rd_addr][l]);
    assign fill_dec[l] = dec(mem[fill_addr][l]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_data[32*l +: 32]   <= '0;
        rd_corr[l]            <= 1'b0;
        fill_data[32*l +: 32] <= '0;
        fill_corr[l]          <= 1'b0;
      end else begin
        if (rd_en) rd_data[32*l +: 32] <= rd_dec[l][31:0];
        rd_corr[l] <= rd_en && rd_dec[l][32];
        if (fill_go || fill_busy) fill_data[32*l +: 32] <= fill_dec[l][31:0];
        fill_corr[l] <= (fill_go || fill_busy) && fill_dec[l][32];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int a = 0; a < DEPTH; a++) mem[a][l] <= '0;
      end else if (wr_en) begin
        if (wr_full || wr_lane == LW'(l))
          mem[wr_addr][l] <= enc(wr_full ? wr_data[32*l +: 32] : wr_data[31:0]);
      end else if (inj_en && inj_lane == LW'(l) && inj_bit < 6'd38) begin
        mem[inj_addr][l][inj_bit] <= ~mem[inj_addr][l][inj_bit];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      nrd_valid  <= 1'b0;
      nrd_data   <= '0;
      nrd_corr   <= 1'b0;
      fill_busy  <= 1'b0;
      fill_valid <= 1'b0;
      fill_last  <= 1'b0;
      blk_q      <= '0;
    end else begin
      rd_valid   <= rd_en;
      nrd_valid  <= nrd_en;
      if (nrd_en) nrd_data <= nrd_dec[31:0];
      nrd_corr   <= nrd_en && nrd_dec[32];
      fill_busy  <= fill_go;
      fill_valid <= fill_go || fill_busy;
      fill_last  <= fill_busy;
      if (fill_go) blk_q <= fill_blk;
    end
  end
endmodule

// File: rtl/lane_ecc_mem_chk.sv
module lane_ecc_mem_chk #(
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [NL-1:0] rd_corr,
  input logic          nrd_en,
  input logic          nrd_valid,
  input logic          nrd_corr,
  input logic          fill_req,
  input logic          fill_valid,
  input logic          fill_last
);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid);
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid);
  // R6
  rd_corr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |-> rd_corr == '0);
  // R7
  nrd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) nrd_en |=> nrd_valid);
  // R7
  nrd_corr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !nrd_valid |-> !nrd_corr);
  // R8
  fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !(fill_valid && !fill_last) |=> fill_valid && !fill_last);
  // R8
  fill_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_last |=> fill_valid && fill_last);
  // R9
  fill_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |-> fill_valid && $past(fill_valid) && !$past(fill_last));
endmodule

bind lane_ecc_mem lane_ecc_mem_chk #(.NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid), .rd_corr(rd_corr),
  .nrd_en(nrd_en), .nrd_valid(nrd_valid), .nrd_corr(nrd_corr),
  .fill_req(fill_req), .fill_valid(fill_valid), .fill_last(fill_last)
);

// File: tb/lane_ecc_mem_tb_top.sv
`timescale 1ns/1ps
module lane_ecc_mem_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_full = 0, rd_en = 0, nrd_en = 0, fill_req = 0, inj_en = 0;
  logic [1:0] wr_lane = 0, nrd_lane = 0, inj_lane = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0, nrd_addr = 0, inj_addr = 0;
  logic [2:0] fill_blk = 0;
  logic [5:0] inj_bit = 0;
  logic [127:0] wr_data = 0;
  logic [127:0] rd_data, fill_data;
  logic [3:0] rd_corr, fill_corr;
  logic rd_valid, nrd_corr, nrd_valid, fill_valid, fill_last;
  logic [31:0] nrd_data;
  int checks = 0, failures = 0, cycles = 0;
  logic done = 0;

  always #5 clk = ~clk;

  lane_ecc_mem dut_i (.*);

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic full, input logic [1:0] ln, input logic [127:0] d);
    wr_en = 1; wr_full = full; wr_lane = ln; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic inj(input logic [3:0] a, input logic [1:0] ln, input logic [5:0] b);
    inj_en = 1; inj_addr = a; inj_lane = ln; inj_bit = b;
    @(negedge clk);
    inj_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 valids", {125'd0, rd_valid, nrd_valid, fill_valid}, 128'd0);
    rd(4'd3);
    chk("R1 data", rd_data, 128'd0);
    chk("R1 corr", {124'd0, rd_corr}, 128'd0);
    @(negedge clk);
    chk("R2 idle valid", {127'd0, rd_valid}, 128'd0);
  endtask

  task automatic t_full();
    wr(4'd0, 1, 0, 128'h0123456789abcdef_fedcba9876543210);
    wr(4'd1, 1, 0, {4{32'hffffffff}});
    wr(4'd15, 1, 0, 128'h80000001_00000000_deadbeef_5a5a5a5a);
    rd(4'd0);
    chk("R2 valid", {127'd0, rd_valid}, 128'd1);
    chk("R2 word0", rd_data, 128'h0123456789abcdef_fedcba9876543210);
    rd(4'd1);
    chk("R2 word1", rd_data, {4{32'hffffffff}});
    rd(4'd15);
    chk("R2 word15", rd_data, 128'h80000001_00000000_deadbeef_5a5a5a5a);
    chk("R6 clean", {124'd0, rd_corr}, 128'd0);
  endtask

  task automatic t_lane();
    wr(4'd2, 1, 0, {32'h33333333, 32'h22222222, 32'h11111111, 32'h00000000});
    wr(4'd2, 0, 2'd2, {96'hffff, 32'hcafef00d});
    rd(4'd2);
    chk("R3 lane2", rd_data, {32'h33333333, 32'hcafef00d, 32'h11111111, 32'h00000000});
    wr(4'd2, 0, 2'd0, {96'd0, 32'h0badf00d});
    rd(4'd2);
    chk("R3 lane0", rd_data, {32'h33333333, 32'hcafef00d, 32'h11111111, 32'h0badf00d});
  endtask

  task automatic t_inject();
    inj(4'd2, 2'd1, 6'd5);
    rd(4'd2);
    chk("R5 data bit", rd_data, {32'h33333333, 32'hcafef00d, 32'h11111111, 32'h0badf00d});
    chk("R6 flag lane1", {124'd0, rd_corr}, 128'h2);
    inj(4'd2, 2'd3, 6'd0);
    inj(4'd2, 2'd0, 6'd40);
    rd(4'd2);
    chk("R5 check bit", rd_data, {32'h33333333, 32'hcafef00d, 32'h11111111, 32'h0badf00d});
    chk("R5 ignore 40", {124'd0, rd_corr}, 128'ha);
    inj(4'd15, 2'd2, 6'd37);
    rd(4'd15);
    chk("R5 top bit", rd_data, 128'h80000001_00000000_deadbeef_5a5a5a5a);
    chk("R6 flag lane2", {124'd0, rd_corr}, 128'h4);
  endtask

  task automatic t_keep();
    wr(4'd2, 0, 2'd0, {96'd0, 32'h12345678});
    rd(4'd2);
    chk("R4 kept flags", {124'd0, rd_corr}, 128'ha);
    chk("R4 data", rd_data, {32'h33333333, 32'hcafef00d, 32'h11111111, 32'h12345678});
    wr(4'd2, 0, 2'd1, {96'd0, 32'h11111111});
    rd(4'd2);
    chk("R6 cleared lane1", {124'd0, rd_corr}, 128'h8);
  endtask

  task automatic t_narrow();
    nrd_en = 1; nrd_addr = 4'd2; nrd_lane = 2'd3;
    @(negedge clk);
    nrd_en = 0;
    chk("R7 data", {96'd0, nrd_data}, {96'd0, 32'h33333333});
    chk("R7 flags", {126'd0, nrd_valid, nrd_corr}, 128'h3);
    nrd_en = 1; nrd_lane = 2'd2;
    @(negedge clk);
    nrd_en = 0;
    chk("R7 lane2", {95'd0, nrd_corr, nrd_data}, {95'd0, 1'b0, 32'hcafef00d});
  endtask

  task automatic t_fill();
    fill_req = 1; fill_blk = 3'd1;
    @(negedge clk);
    fill_blk = 3'd7;
    chk("R8 beat0", fill_data, {32'h33333333, 32'hcafef00d, 32'h11111111, 32'h12345678});
    chk("R8 beat0 flags", {122'd0, fill_valid, fill_last, fill_corr}, {122'd0, 2'b10, 4'h8});
    @(negedge clk);
    fill_req = 0;
    chk("R8 beat1", fill_data, 128'd0);
    chk("R8 beat1 flags", {122'd0, fill_valid, fill_last, fill_corr}, {122'd0, 2'b11, 4'h0});
    @(negedge clk);
    chk("R9 no extra beat", {127'd0, fill_valid}, 128'd0);
  endtask

  task automatic t_same_cycle();
    wr_en = 1; wr_full = 1; wr_addr = 4'd0; wr_data = {4{32'h55aa55aa}};
    rd_en = 1; rd_addr = 4'd0;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R10 old data", rd_data, 128'h0123456789abcdef_fedcba9876543210);
    rd(4'd0);
    chk("R10 new data", rd_data, {4{32'h55aa55aa}});
  endtask

  task automatic t_inj_blocked();
    wr_en = 1; wr_full = 1; wr_addr = 4'd6; wr_data = {4{32'h0f0f0f0f}};
    inj_en = 1; inj_addr = 4'd7; inj_lane = 2'd0; inj_bit = 6'd3;
    @(negedge clk);
    wr_en = 0; inj_en = 0;
    rd(4'd7);
    chk("R11 no flag", {124'd0, rd_corr}, 128'd0);
    chk("R11 data", rd_data, 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_lane();
    t_inject();
    t_keep();
    t_narrow();
    t_fill();
    t_same_cycle();
    t_inj_blocked();
    done = 1;
    finish_run();
  end
endmodule